// File: doc/BRIEF.md
# Two-Port Shared Memory Bank Arbiter

This block sits between two neighbouring compute units and a row of small, independently addressable memory banks that both units can reach. Each unit issues at most one single-word access per cycle. An access names a bank index, a word address inside that bank, a write flag and write data. The block steers each bank to one unit at a time. When only one unit wants a bank, that unit gets it in the same cycle. When both units want the same bank in the same cycle, the unit that lost the last contest for that bank wins. The other unit sees its grant low and keeps its request posted until it is granted.

The banks themselves sit outside the block and are expected to be synchronous. A bank writes on the edge where its enable is high with the write flag set. After an enabled read, it presents the addressed word on its read-data slice from the following edge. The block records which bank each unit read from and routes that bank's output back to the requester one cycle after the grant, together with a valid strobe. Because the units run independently, requests from either side may arrive in any cycle. A bank access completes in one cycle, so a bank is free again on the cycle after its grant.

Top module: `mem_bank_arbiter`

## Requirements
- R1: A unit whose request names a bank that the other unit is not requesting in the same cycle is granted in that same cycle. That bank's enable is high, and its address, write flag and write data are the requesting unit's values. Bank indices used must be below NBANK.
- R2: Requests from the two units to two different banks are both granted in the same cycle, each bank carrying its own requester's fields.
- R3: When both units request the same bank in the same cycle, exactly one grant is high. That bank carries the winner's fields. A unit that requests and is not granted is always blocked by the other unit holding that very bank.
- R4: For each bank, the first same-cycle contest after reset is won by unit A. Every later contest on that bank is won by the unit that lost the previous contest on it. Uncontested accesses leave this order unchanged, and every bank keeps its own order.
- R5: A unit that loses a contest and keeps the same request posted is granted in the next cycle, whatever the other unit requests then.
- R6: One cycle after a granted read (write flag 0), the unit's read-valid output is high and its read-data output equals the read-data slice of the bank it was granted. In every other cycle, read-valid is low and read data is zero. A granted write never raises read-valid.
- R7: During and right after reset, with no requests, both grants, all bank enables, all bank write flags and both read-valid outputs are low.
- R8: A bank that no unit is granted in a cycle has its enable and write flag low, and its address and write data are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_req | input | 1 | Unit A access request |
| a_bank | input | BSW | Unit A bank index |
| a_addr | input | AW | Unit A word address within the bank |
| a_we | input | 1 | Unit A write flag (1 = write, 0 = read) |
| a_wdata | input | DW | Unit A write data |
| a_gnt | output | 1 | Unit A granted this cycle |
| a_rvalid | output | 1 | Unit A read data valid |
| a_rdata | output | DW | Unit A read data |
| b_req | input | 1 | Unit B access request |
| b_bank | input | BSW | Unit B bank index |
| b_addr | input | AW | Unit B word address within the bank |
| b_we | input | 1 | Unit B write flag (1 = write, 0 = read) |
| b_wdata | input | DW | Unit B write data |
| b_gnt | output | 1 | Unit B granted this cycle |
| b_rvalid | output | 1 | Unit B read data valid |
| b_rdata | output | DW | Unit B read data |
| bank_en | output | NBANK | Per-bank access enable |
| bank_we | output | NBANK | Per-bank write flag |
| bank_addr | output | NBANK*AW | Per-bank word address, bank i at bits i*AW upward |
| bank_wdata | output | NBANK*DW | Per-bank write data, bank i at bits i*DW upward |
| bank_rdata | input | NBANK*DW | Per-bank read data, bank i at bits i*DW upward |

## Verification
The directed part starts with lone accesses from each unit, which separate correct same-cycle granting and field steering from a swapped or delayed path. Accesses to two different banks at once show whether one unit's traffic leaks into the other's bank. Back-to-back contests on one bank, with the loser holding its request, tell true alternation apart from a fixed priority. Uncontested accesses between two contests show whether the order wrongly moves without a contest. The random part narrows bank choice to a few indices, so it produces dense contention, stalls and read-after-write traffic. This is where a wrong bank tag on returned read data, or a shared instead of per-bank order, becomes visible.

// File: rtl/mba_pkg.sv
package mba_pkg;

    // Which compute unit currently drives a bank.
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_A    = 2'd1,
        OWN_B    = 2'd2
    } owner_e;

endpackage

// File: rtl/mba_bank_arb.sv
module mba_bank_arb
    import mba_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   want_a,
    input  logic   want_b,
    output owner_e owner
);

    typedef struct packed {
        logic favor_b;   // 1: unit B wins the next contest
    } arb_state_t;

    arb_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        owner = OWN_NONE;
        if (want_a && want_b) begin
            if (st_q.favor_b) begin
                owner        = OWN_B;
                st_d.favor_b = 1'b0;
            end else begin
                owner        = OWN_A;
                st_d.favor_b = 1'b1;
            end
        end else if (want_a) begin
            owner = OWN_A;
        end else if (want_b) begin
            owner = OWN_B;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: a contest won by A makes B the winner of the next contest, and vice versa
    a_r4_alt_after_a: assert property (@(posedge clk) disable iff (!rst_n)
        (want_a && want_b && owner == OWN_A) |=> (!(want_a && want_b) || owner == OWN_B));
    a_r4_alt_after_b: assert property (@(posedge clk) disable iff (!rst_n)
        (want_a && want_b && owner == OWN_B) |=> (!(want_a && want_b) || owner == OWN_A));

endmodule

// File: rtl/mba_cmd_mux.sv
module mba_cmd_mux
    import mba_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  owner_e          owner,
    input  logic [AW-1:0]   a_addr,
    input  logic            a_we,
    input  logic [DW-1:0]   a_wdata,
    input  logic [AW-1:0]   b_addr,
    input  logic            b_we,
    input  logic [DW-1:0]   b_wdata,
    output logic            en,
    output logic            we,
    output logic [AW-1:0]   addr,
    output logic [DW-1:0]   wdata
);

    typedef struct packed {
        logic          en;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } cmd_t;

    cmd_t cmd_d;

    always_comb begin
        cmd_d = '0;
        unique case (owner)
            OWN_A: begin
                cmd_d.en    = 1'b1;
                cmd_d.we    = a_we;
                cmd_d.addr  = a_addr;
                cmd_d.wdata = a_wdata;
            end
            OWN_B: begin
                cmd_d.en    = 1'b1;
                cmd_d.we    = b_we;
                cmd_d.addr  = b_addr;
                cmd_d.wdata = b_wdata;
            end
            default: cmd_d = '0;
        endcase
    end

    assign en    = cmd_d.en;
    assign we    = cmd_d.we;
    assign addr  = cmd_d.addr;
    assign wdata = cmd_d.wdata;

endmodule

// File: rtl/mba_rd_return.sv
module mba_rd_return #(
    parameter int NBANK = 8,
    parameter int DW    = 16,
    localparam int BSW  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gnt,
    input  logic                we,
    input  logic [BSW-1:0]      bank,
    input  logic [NBANK*DW-1:0] bank_rdata,
    output logic                rvalid,
    output logic [DW-1:0]       rdata
);

    typedef struct packed {
        logic           rvalid;
        logic [BSW-1:0] rbank;
    } ret_state_t;

    ret_state_t st_d, st_q;
    logic [DW-1:0] sel_data;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = gnt && !we;
        if (gnt && !we) begin
            st_d.rbank = bank;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        sel_data = '0;
        for (int i = 0; i < NBANK; i++) begin
            if (st_q.rbank == BSW'(i)) begin
                sel_data = bank_rdata[i*DW +: DW];
            end
        end
    end

    assign rvalid = st_q.rvalid;
    assign rdata  = st_q.rvalid ? sel_data : '0;

    // R6: a granted read is answered in the next cycle, nothing else raises read-valid
    a_r6_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt && !we) |=> rvalid);
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(gnt && !we) |=> (!rvalid && rdata == '0));

endmodule

// File: rtl/mem_bank_arbiter.sv
module mem_bank_arbiter
    import mba_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int AW    = 10,
    parameter int DW    = 16,
    localparam int BSW  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                a_req,
    input  logic [BSW-1:0]      a_bank,
    input  logic [AW-1:0]       a_addr,
    input  logic                a_we,
    input  logic [DW-1:0]       a_wdata,
    output logic                a_gnt,
    output logic                a_rvalid,
    output logic [DW-1:0]       a_rdata,
    input  logic                b_req,
    input  logic [BSW-1:0]      b_bank,
    input  logic [AW-1:0]       b_addr,
    input  logic                b_we,
    input  logic [DW-1:0]       b_wdata,
    output logic                b_gnt,
    output logic                b_rvalid,
    output logic [DW-1:0]       b_rdata,
    output logic [NBANK-1:0]    bank_en,
    output logic [NBANK-1:0]    bank_we,
    output logic [NBANK*AW-1:0] bank_addr,
    output logic [NBANK*DW-1:0] bank_wdata,
    input  logic [NBANK*DW-1:0] bank_rdata
);

    logic [NBANK-1:0] want_a, want_b;
    logic [NBANK-1:0] won_a, won_b;
    owner_e           own [NBANK];

    for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
        assign want_a[gi] = a_req && (a_bank == BSW'(gi));
        assign want_b[gi] = b_req && (b_bank == BSW'(gi));

        mba_bank_arb u_arb (
            .clk    (clk),
            .rst_n  (rst_n),
            .want_a (want_a[gi]),
            .want_b (want_b[gi]),
            .owner  (own[gi])
        );

        mba_cmd_mux #(
            .AW (AW),
            .DW (DW)
        ) u_mux (
            .owner   (own[gi]),
            .a_addr  (a_addr),
            .a_we    (a_we),
            .a_wdata (a_wdata),
            .b_addr  (b_addr),
            .b_we    (b_we),
            .b_wdata (b_wdata),
            .en      (bank_en[gi]),
            .we      (bank_we[gi]),
            .addr    (bank_addr[gi*AW +: AW]),
            .wdata   (bank_wdata[gi*DW +: DW])
        );

        assign won_a[gi] = (own[gi] == OWN_A);
        assign won_b[gi] = (own[gi] == OWN_B);

        // R8: an enabled bank always belongs to exactly the unit granted for it
        a_r8_en_owned: assert property (@(posedge clk) disable iff (!rst_n)
            bank_en[gi] |-> ((a_gnt && a_bank == BSW'(gi)) ^ (b_gnt && b_bank == BSW'(gi))));
    end

    assign a_gnt = |(want_a & won_a);
    assign b_gnt = |(want_b & won_b);

    mba_rd_return #(
        .NBANK (NBANK),
        .DW    (DW)
    ) u_ret_a (
        .clk        (clk),
        .rst_n      (rst_n),
        .gnt        (a_gnt),
        .we         (a_we),
        .bank       (a_bank),
        .bank_rdata (bank_rdata),
        .rvalid     (a_rvalid),
        .rdata      (a_rdata)
    );

    mba_rd_return #(
        .NBANK (NBANK),
        .DW    (DW)
    ) u_ret_b (
        .clk        (clk),
        .rst_n      (rst_n),
        .gnt        (b_gnt),
        .we         (b_we),
        .bank       (b_bank),
        .bank_rdata (bank_rdata),
        .rvalid     (b_rvalid),
        .rdata      (b_rdata)
    );

    // R1: an uncontested request is granted at once
    a_r1_lone_a: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && !(b_req && b_bank == a_bank)) |-> a_gnt);
    a_r1_lone_b: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req && !(a_req && a_bank == b_bank)) |-> b_gnt);

    // R3: never two owners for one bank, and a stall is always caused by the other unit
    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (a_gnt && b_gnt) |-> (a_bank != b_bank));
    a_r3_stall_a: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && !a_gnt) |-> (b_gnt && b_bank == a_bank));
    a_r3_stall_b: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req && !b_gnt) |-> (a_gnt && a_bank == b_bank));

    // R5: a loser that keeps its request is served in the following cycle
    a_r5_retry_a: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && !a_gnt) |=> (!(a_req && a_bank == $past(a_bank)) || a_gnt));
    a_r5_retry_b: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req && !b_gnt) |=> (!(b_req && b_bank == $past(b_bank)) || b_gnt));

endmodule

// File: tb/mem_bank_arbiter_tb.sv
`timescale 1ns/1ps
module mem_bank_arbiter_tb;

    localparam int NB  = 8;
    localparam int AW  = 6;
    localparam int DW  = 16;
    localparam int BSW = 3;
    localparam int NW  = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic           a_req = 1'b0, b_req = 1'b0;
    logic [BSW-1:0] a_bank = '0, b_bank = '0;
    logic [AW-1:0]  a_addr = '0, b_addr = '0;
    logic           a_we = 1'b0, b_we = 1'b0;
    logic [DW-1:0]  a_wdata = '0, b_wdata = '0;
    logic           a_gnt, b_gnt, a_rvalid, b_rvalid;
    logic [DW-1:0]  a_rdata, b_rdata;
    logic [NB-1:0]  bank_en, bank_we;
    logic [NB*AW-1:0] bank_addr;
    logic [NB*DW-1:0] bank_wdata;
    logic [NB*DW-1:0] bank_rdata;

    mem_bank_arbiter #(.NBANK(NB), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_bank(a_bank), .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata),
        .a_gnt(a_gnt), .a_rvalid(a_rvalid), .a_rdata(a_rdata),
        .b_req(b_req), .b_bank(b_bank), .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata),
        .b_gnt(b_gnt), .b_rvalid(b_rvalid), .b_rdata(b_rdata),
        .bank_en(bank_en), .bank_we(bank_we), .bank_addr(bank_addr),
        .bank_wdata(bank_wdata), .bank_rdata(bank_rdata)
    );

    function automatic logic [DW-1:0] seed_word(int bk, int wd);
        return DW'((bk * 131 + wd * 7) ^ 16'h5a5a);
    endfunction

    // Bank storage emulation: synchronous write, registered read
    logic [DW-1:0] ram [NB][NW];
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_rdata <= '0;
            for (int i = 0; i < NB; i++)
                for (int j = 0; j < NW; j++)
                    ram[i][j] <= seed_word(i, j);
        end else begin
            for (int i = 0; i < NB; i++) begin
                if (bank_en[i]) begin
                    if (bank_we[i]) ram[i][bank_addr[i*AW +: AW]] <= bank_wdata[i*DW +: DW];
                    else            bank_rdata[i*DW +: DW] <= ram[i][bank_addr[i*AW +: AW]];
                end
            end
        end
    end

    // Independent reference state
    logic [DW-1:0] ref_mem [NB][NW];
    bit            fav_b [NB];
    bit            exp_rv_a = 0, exp_rv_b = 0;
    logic [DW-1:0] exp_rd_a = '0, exp_rd_b = '0;
    bit            last_ga = 0, last_gb = 0;
    int            n_checks = 0, n_fail = 0;
    bit            done = 0;

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_returns();
        chk(a_rvalid === exp_rv_a, "R6 a_rvalid", 64'(a_rvalid), 64'(exp_rv_a));
        chk(a_rdata === (exp_rv_a ? exp_rd_a : '0), "R6 a_rdata", 64'(a_rdata), 64'(exp_rv_a ? exp_rd_a : '0));
        chk(b_rvalid === exp_rv_b, "R6 b_rvalid", 64'(b_rvalid), 64'(exp_rv_b));
        chk(b_rdata === (exp_rv_b ? exp_rd_b : '0), "R6 b_rdata", 64'(b_rdata), 64'(exp_rv_b ? exp_rd_b : '0));
    endtask

    // One cycle: drive at the falling edge, check combinational outputs, update reference
    task automatic step(bit ar, int ab, int aa, bit aw, logic [DW-1:0] ad,
                        bit br, int bb, int ba, bit bw, logic [DW-1:0] bd, string tag);
        bit ea, eb, contest;
        logic [NB-1:0] een, ewe;
        @(negedge clk);
        check_returns();
        a_req = ar; a_bank = BSW'(ab); a_addr = AW'(aa); a_we = aw; a_wdata = ad;
        b_req = br; b_bank = BSW'(bb); b_addr = AW'(ba); b_we = bw; b_wdata = bd;
        #1;
        contest = ar && br && (ab == bb);
        if (contest) begin
            ea = !fav_b[ab];
            eb = fav_b[ab];
        end else begin
            ea = ar;
            eb = br;
        end
        een = '0; ewe = '0;
        if (ea) begin een[ab] = 1'b1; ewe[ab] = aw; end
        if (eb) begin een[bb] = 1'b1; ewe[bb] = bw; end
        chk(a_gnt === ea, {tag, " a_gnt"}, 64'(a_gnt), 64'(ea));
        chk(b_gnt === eb, {tag, " b_gnt"}, 64'(b_gnt), 64'(eb));
        chk(bank_en === een, "R8 bank_en", 64'(bank_en), 64'(een));
        chk(bank_we === ewe, "R8 bank_we", 64'(bank_we), 64'(ewe));
        for (int i = 0; i < NB; i++) begin
            if (!een[i]) begin
                chk(bank_addr[i*AW +: AW] === '0 && bank_wdata[i*DW +: DW] === '0,
                    "R8 idle fields", 64'(bank_wdata[i*DW +: DW]), 64'(0));
            end
        end
        if (ea) begin
            chk(bank_addr[ab*AW +: AW] === AW'(aa), {tag, " addr A"}, 64'(bank_addr[ab*AW +: AW]), 64'(aa));
            if (aw) chk(bank_wdata[ab*DW +: DW] === ad, {tag, " wdata A"}, 64'(bank_wdata[ab*DW +: DW]), 64'(ad));
        end
        if (eb) begin
            chk(bank_addr[bb*AW +: AW] === BSW'(0) + AW'(ba), {tag, " addr B"}, 64'(bank_addr[bb*AW +: AW]), 64'(ba));
            if (bw) chk(bank_wdata[bb*DW +: DW] === bd, {tag, " wdata B"}, 64'(bank_wdata[bb*DW +: DW]), 64'(bd));
        end
        // reference update
        if (contest) fav_b[ab] = ea;
        exp_rv_a = ea && !aw;
        exp_rv_b = eb && !bw;
        if (exp_rv_a) exp_rd_a = ref_mem[ab][aa];
        if (exp_rv_b) exp_rd_b = ref_mem[bb][ba];
        if (ea && aw) ref_mem[ab][aa] = ad;
        if (eb && bw) ref_mem[bb][ba] = bd;
        last_ga = ea;
        last_gb = eb;
    endtask

    task automatic idle(string tag);
        step(0, 0, 0, 0, '0, 0, 0, 0, 0, '0, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        bit pa, pb, paw, pbw;
        int pab, pbb, paa, pba;
        logic [DW-1:0] pad, pbd;
        int unsigned dummy;
        dummy = $urandom(32'd20240531);
        for (int i = 0; i < NB; i++) begin
            fav_b[i] = 0;
            for (int j = 0; j < NW; j++) ref_mem[i][j] = seed_word(i, j);
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: reset state
        chk(a_gnt === 1'b0 && b_gnt === 1'b0, "R7 grants in reset", 64'({a_gnt, b_gnt}), 64'(0));
        chk(bank_en === '0 && bank_we === '0, "R7 bank enables in reset", 64'(bank_en), 64'(0));
        chk(a_rvalid === 1'b0 && b_rvalid === 1'b0, "R7 rvalid in reset", 64'({a_rvalid, b_rvalid}), 64'(0));
        rst_n = 1'b1;
        idle("R7");
        idle("R7");

        // R1: lone write by A, lone read of it by B (R6 return checked next cycle)
        step(1, 2, 5, 1, 16'h1234, 0, 0, 0, 0, '0, "R1");
        step(0, 0, 0, 0, '0, 1, 2, 5, 0, '0, "R1");
        step(1, 6, 9, 0, '0, 0, 0, 0, 0, '0, "R1");
        idle("R6");

        // R2: two different banks at once
        step(1, 1, 3, 1, 16'hbeef, 1, 4, 7, 1, 16'hcafe, "R2");
        step(1, 4, 7, 0, '0, 1, 1, 3, 0, '0, "R2");
        idle("R6");

        // R4 / R5: contests on bank 3
        step(1, 3, 10, 1, 16'h0a0a, 1, 3, 11, 1, 16'h0b0b, "R4");   // A wins (first contest)
        step(1, 3, 12, 0, '0, 1, 3, 11, 1, 16'h0b0b, "R5");          // B retries and wins
        step(1, 3, 12, 0, '0, 0, 0, 0, 0, '0, "R5");                 // A retries alone
        step(0, 0, 0, 0, '0, 1, 3, 10, 0, '0, "R4");                 // uncontested
        step(1, 3, 11, 0, '0, 0, 0, 0, 0, '0, "R4");                 // uncontested
        step(1, 3, 13, 1, 16'h0c0c, 1, 3, 14, 1, 16'h0d0d, "R4");   // A wins: last contest won by B
        step(1, 5, 1, 1, 16'h5151, 1, 5, 2, 1, 16'h5252, "R4");     // own order on bank 5: A
        step(1, 3, 14, 0, '0, 1, 3, 14, 0, '0, "R4");                // bank 3: B wins
        idle("R6");

        // Constrained random traffic with stall holding
        pa = 0; pb = 0; paw = 0; pbw = 0; pab = 0; pbb = 0; paa = 0; pba = 0; pad = '0; pbd = '0;
        for (int n = 0; n < 3000; n++) begin
            bit hold_a, hold_b;
            string tg;
            hold_a = pa && !last_ga;
            hold_b = pb && !last_gb;
            if (!hold_a) begin
                pa  = ($urandom_range(0, 3) != 0);
                pab = ($urandom_range(0, 1) != 0) ? int'($urandom_range(0, 2)) : int'($urandom_range(0, NB-1));
                paa = int'($urandom_range(0, NW-1));
                paw = $urandom_range(0, 1) != 0;
                pad = DW'($urandom);
            end
            if (!hold_b) begin
                pb  = ($urandom_range(0, 3) != 0);
                pbb = ($urandom_range(0, 1) != 0) ? int'($urandom_range(0, 2)) : int'($urandom_range(0, NB-1));
                pba = int'($urandom_range(0, NW-1));
                pbw = $urandom_range(0, 1) != 0;
                pbd = DW'($urandom);
            end
            if (hold_a || hold_b)                 tg = "R5";
            else if (pa && pb && pab == pbb)      tg = "R3";
            else if (pa && pb)                    tg = "R2";
            else                                  tg = "R1";
            step(pa, pab, paa, paw, pad, pb, pbb, pba, pbw, pbd, tg);
        end
        idle("R6");
        idle("R6");
        @(negedge clk);
        check_returns();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule